// File: doc/BRIEF.md
# Interrupt Mapping and Request Controller

This block collects 64 level-sensitive interrupt lines and turns them into a single outstanding request, shown both as a 7-bit request number and as a one-hot vector. Lines 0 to 31 belong to PCI slots and are governed four at a time by eight PCI mapping registers. Lines 32 to 63 belong to onboard devices, and each has its own mapping register. Every mapping register carries an enable bit, a writable target field and a fixed interrupt-number field.

Software uses a small register bus to program the mapping registers and to retire the current request through clear registers. A rising PCI line that is enabled takes the request at once, even when another request is outstanding. An onboard line is granted only when no request is held. After a request is retired, the lowest-numbered line that is high and enabled is granted on the following clock edge.

A separate combinational port converts a PCI slot, pin and function-number parity bit into the line number that the slot drives.

Top module: `irqmap_ctrl`

## Requirements
- R1: PCI line n is governed by the enable of PCI mapping register n/4. Onboard line n (32..63) is governed by onboard mapping register n-32.
- R2: The route output is (16 if the function bit is 1, else 0) + 4*slot + pin, taken modulo 32.
- R3: At the clock edge where a PCI line rises with its enable set, that line becomes the request, replacing any request already held. A rising line whose enable is clear raises no request.
- R4: An enabled onboard line is granted only while no request is held.
- R5: A mapping register is at bus address region*256 + index*8 + 4. Region 0 holds the PCI registers, with the index in bits [5:3]. Region 1 holds the onboard registers, with the index in bits [7:3]. Bit 31 is the enable and bits [10:6] are the target; both are writable. Bits [5:0] read back the line number (4*index for PCI, 32+index for onboard) and ignore writes.
- R6: A mapping-register write whose bit 31 and bits [10:6] are all zero retires the current request if that register governs the requested line. Any other write leaves the request in place.
- R7: A write at region 2 (PCI clear, index in bits [7:5]) retires the request when request/4 equals the index. A write at region 3 (onboard clear, index in bits [7:3]) retires the request when the request equals 32+index. Bit 2 of the address must be 1 in both cases.
- R8: The request reads 7'h7F in the cycle after it is retired. On the next edge the lowest-numbered line that is high and enabled is granted.
- R9: Power-on reset loads PCI register i with target 5'h1F, and onboard register i likewise. Warm reset clears only the enable and target fields. Both resets set the request to 7'h7F. Reads with address bit 2 at 0, and reads of the clear regions, return zero.
- R10: req_vec has exactly the bit of req_id set, and is all zero while req_id is 7'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | Warm reset, synchronous, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_lvl | input | 64 | Interrupt line levels |
| req_id | output | 7 | Current request number, 7'h7F when none |
| req_vec | output | 64 | One-hot form of the current request |
| rt_slot | input | 5 | Slot number to route |
| rt_pin | input | 2 | Interrupt pin of the slot (0..3) |
| rt_fn_lsb | input | 1 | Bit 0 of the function number |
| rt_line | output | 5 | Line number the slot pin drives |

## Verification
The checker assumes that bus_wr is a single-cycle strobe with a stable address. It also assumes that both resets are held over a clock edge, with warm reset never released ahead of power-on reset. The bench meets these conditions by driving every input at the falling edge, pulsing bus_wr for exactly one cycle and releasing both resets together. The checker places no limit on how the interrupt lines change. The bench still moves one line per cycle, so that each grant can be traced to a single rising edge or to a single arbitration step.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
   localparam int DEF_N_PCI  = 32;
   localparam int DEF_N_OB   = 32;
   localparam int DEF_GRP    = 4;
   localparam int DEF_TGT_W  = 5;
   localparam int DEF_ADDR_W = 12;
   localparam int DEF_DATA_W = 32;
   localparam int DEF_SLOT_W = 5;
   localparam int EN_BIT     = 31;
   localparam int TGT_LSB    = 6;

   typedef enum logic [3:0] {
      RG_PMAP = 4'h0,
      RG_OMAP = 4'h1,
      RG_PCLR = 4'h2,
      RG_OCLR = 4'h3
   } region_e;
endpackage

// File: rtl/irqmap_route.sv
module irqmap_route #(
   parameter int N_PCI  = irqmap_pkg::DEF_N_PCI,
   parameter int GRP    = irqmap_pkg::DEF_GRP,
   parameter int SLOT_W = irqmap_pkg::DEF_SLOT_W
) (
   input  logic [SLOT_W-1:0]        slot,
   input  logic [$clog2(GRP)-1:0]   pin,
   input  logic                     fn_lsb,
   output logic [$clog2(N_PCI)-1:0] line
);
   localparam int LINE_W = $clog2(N_PCI);
   localparam int GRP_SH = $clog2(GRP);
   localparam int HALF   = N_PCI / 2;

   logic [LINE_W-1:0] base, slot_off;
   assign base     = fn_lsb ? LINE_W'(HALF) : '0;
   assign slot_off = LINE_W'(slot) << GRP_SH;
   assign line     = base + slot_off + LINE_W'(pin);
endmodule

// File: rtl/irqmap_regs.sv
module irqmap_regs #(
   parameter int N_PCI  = irqmap_pkg::DEF_N_PCI,
   parameter int N_OB   = irqmap_pkg::DEF_N_OB,
   parameter int GRP    = irqmap_pkg::DEF_GRP,
   parameter int TGT_W  = irqmap_pkg::DEF_TGT_W,
   parameter int ADDR_W = irqmap_pkg::DEF_ADDR_W,
   parameter int DATA_W = irqmap_pkg::DEF_DATA_W
) (
   input  logic                    clk,
   input  logic                    por_n,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [N_PCI+N_OB-1:0]   line_en,
   output logic [N_PCI+N_OB-1:0]   zero_mask,
   output logic [N_PCI+N_OB-1:0]   clr_mask
);
   import irqmap_pkg::*;

   localparam int N_LINES  = N_PCI + N_OB;
   localparam int N_PMAP   = N_PCI / GRP;
   localparam int GRP_SH   = $clog2(GRP);
   localparam int PIDX_W   = $clog2(N_PMAP);
   localparam int OIDX_W   = $clog2(N_OB);
   localparam int INO_W    = $clog2(N_LINES);
   localparam int PCLR_LSB = 3 + GRP_SH;

   logic [3:0]        region;
   logic              odd, wr_odd, w_en, w_zero;
   logic [TGT_W-1:0]  w_tgt;
   logic [PIDX_W-1:0] pidx, cidx;
   logic [OIDX_W-1:0] oidx;

   assign region = bus_addr[11:8];
   assign odd    = bus_addr[2];
   assign wr_odd = bus_wr & odd;
   assign pidx   = bus_addr[3 +: PIDX_W];
   assign cidx   = bus_addr[PCLR_LSB +: PIDX_W];
   assign oidx   = bus_addr[3 +: OIDX_W];
   assign w_en   = bus_wdata[EN_BIT];
   assign w_tgt  = bus_wdata[TGT_LSB +: TGT_W];
   assign w_zero = !w_en && (w_tgt == '0);

   logic [N_PMAP-1:0]       p_en;
   logic [N_PMAP*TGT_W-1:0] p_tgt;
   logic [N_OB-1:0]         o_en;
   logic [N_OB*TGT_W-1:0]   o_tgt;

   for (genvar k = 0; k < N_PMAP; k++) begin : g_pmap
      logic             we, en_q;
      logic [TGT_W-1:0] tgt_q;
      assign we = wr_odd && (region == RG_PMAP) && (pidx == PIDX_W'(k));
      always_ff @(posedge clk) begin
         if (!por_n) begin
            en_q  <= 1'b0;
            tgt_q <= '1;
         end else if (!rst_n) begin
            en_q  <= 1'b0;
            tgt_q <= '0;
         end else if (we) begin
            en_q  <= w_en;
            tgt_q <= w_tgt;
         end
      end
      assign p_en[k]                    = en_q;
      assign p_tgt[k*TGT_W +: TGT_W]    = tgt_q;
      assign line_en[k*GRP +: GRP]      = {GRP{en_q}};
      assign zero_mask[k*GRP +: GRP]    = {GRP{we & w_zero}};
      assign clr_mask[k*GRP +: GRP]     =
         {GRP{wr_odd && (region == RG_PCLR) && (cidx == PIDX_W'(k))}};
   end

   for (genvar k = 0; k < N_OB; k++) begin : g_omap
      logic             we, en_q;
      logic [TGT_W-1:0] tgt_q;
      assign we = wr_odd && (region == RG_OMAP) && (oidx == OIDX_W'(k));
      always_ff @(posedge clk) begin
         if (!por_n) begin
            en_q  <= 1'b0;
            tgt_q <= '1;
         end else if (!rst_n) begin
            en_q  <= 1'b0;
            tgt_q <= '0;
         end else if (we) begin
            en_q  <= w_en;
            tgt_q <= w_tgt;
         end
      end
      assign o_en[k]                 = en_q;
      assign o_tgt[k*TGT_W +: TGT_W] = tgt_q;
      assign line_en[N_PCI+k]        = en_q;
      assign zero_mask[N_PCI+k]      = we & w_zero;
      assign clr_mask[N_PCI+k]       =
         wr_odd && (region == RG_OCLR) && (oidx == OIDX_W'(k));
   end

   always_comb begin
      bus_rdata = '0;
      if (odd) begin
         if (region == RG_PMAP) begin
            bus_rdata[EN_BIT]              = p_en[pidx];
            bus_rdata[TGT_LSB +: TGT_W]    = p_tgt[pidx*TGT_W +: TGT_W];
            bus_rdata[INO_W-1:0]           = INO_W'(pidx) << GRP_SH;
         end else if (region == RG_OMAP) begin
            bus_rdata[EN_BIT]              = o_en[oidx];
            bus_rdata[TGT_LSB +: TGT_W]    = o_tgt[oidx*TGT_W +: TGT_W];
            bus_rdata[INO_W-1:0]           = INO_W'(N_PCI) + INO_W'(oidx);
         end
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr, bus_wdata};
endmodule

// File: rtl/irqmap_arb.sv
module irqmap_arb #(
   parameter int N_PCI = irqmap_pkg::DEF_N_PCI,
   parameter int N_OB  = irqmap_pkg::DEF_N_OB
) (
   input  logic                          clk,
   input  logic                          por_n,
   input  logic                          rst_n,
   input  logic [N_PCI+N_OB-1:0]         irq_lvl,
   input  logic [N_PCI+N_OB-1:0]         line_en,
   input  logic [N_PCI+N_OB-1:0]         kill_mask,
   output logic [$clog2(N_PCI+N_OB):0]   req_id,
   output logic [N_PCI+N_OB-1:0]         req_vec
);
   localparam int N_LINES = N_PCI + N_OB;
   localparam int ID_W    = $clog2(N_LINES) + 1;
   localparam logic [ID_W-1:0] ID_NONE = '1;

   function automatic logic [ID_W-1:0] lowest(input logic [N_LINES-1:0] v);
      lowest = ID_NONE;
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (v[i]) lowest = ID_W'(i);
      end
   endfunction

   logic [N_LINES-1:0] pend, rise, cand, pci_fire;
   logic [ID_W-1:0]    req_q, req_d;
   logic               kill;

   assign rise     = irq_lvl & ~pend;
   assign cand     = irq_lvl & line_en;
   assign pci_fire = {{N_OB{1'b0}}, rise[N_PCI-1:0] & line_en[N_PCI-1:0]};
   assign kill     = (req_q != ID_NONE) && kill_mask[req_q[ID_W-2:0]];

   always_comb begin
      req_d = req_q;
      if (kill)
         req_d = ID_NONE;
      else if (|pci_fire)
         req_d = lowest(pci_fire);
      else if (req_q == ID_NONE)
         req_d = lowest(cand);
   end

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         pend  <= '0;
         req_q <= ID_NONE;
      end else begin
         pend  <= irq_lvl;
         req_q <= req_d;
      end
   end

   assign req_id = req_q;
   for (genvar i = 0; i < N_LINES; i++) begin : g_vec
      assign req_vec[i] = (req_q == ID_W'(i));
   end
endmodule

// File: rtl/irqmap_ctrl.sv
module irqmap_ctrl #(
   parameter int N_PCI  = irqmap_pkg::DEF_N_PCI,
   parameter int N_OB   = irqmap_pkg::DEF_N_OB,
   parameter int GRP    = irqmap_pkg::DEF_GRP,
   parameter int TGT_W  = irqmap_pkg::DEF_TGT_W,
   parameter int ADDR_W = irqmap_pkg::DEF_ADDR_W,
   parameter int DATA_W = irqmap_pkg::DEF_DATA_W,
   parameter int SLOT_W = irqmap_pkg::DEF_SLOT_W
) (
   input  logic                          clk,
   input  logic                          por_n,
   input  logic                          rst_n,
   input  logic                          bus_wr,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   input  logic [N_PCI+N_OB-1:0]         irq_lvl,
   output logic [$clog2(N_PCI+N_OB):0]   req_id,
   output logic [N_PCI+N_OB-1:0]         req_vec,
   input  logic [SLOT_W-1:0]             rt_slot,
   input  logic [$clog2(GRP)-1:0]        rt_pin,
   input  logic                          rt_fn_lsb,
   output logic [$clog2(N_PCI)-1:0]      rt_line
);
   localparam int N_LINES = N_PCI + N_OB;

   if (N_PCI % GRP != 0) begin : g_bad_grp
      $error("N_PCI must be a multiple of GRP");
   end
   if ((1 << $clog2(N_LINES)) != N_LINES || (1 << $clog2(GRP)) != GRP) begin : g_bad_pow
      $error("line count and group size must be powers of two");
   end
   if (DATA_W != 32 || ADDR_W < 12) begin : g_bad_bus
      $error("bus needs 32-bit data and at least 12 address bits");
   end
   if (3 + $clog2(N_OB) > 8 || 3 + $clog2(N_PCI) > 8) begin : g_bad_idx
      $error("register index fields exceed address bits [7:3]");
   end
   if ($clog2(N_LINES) > irqmap_pkg::TGT_LSB ||
       irqmap_pkg::TGT_LSB + TGT_W > irqmap_pkg::EN_BIT) begin : g_bad_fld
      $error("mapping register fields overlap");
   end

   logic [N_LINES-1:0] line_en, zero_mask, clr_mask;

   irqmap_regs #(
      .N_PCI(N_PCI), .N_OB(N_OB), .GRP(GRP), .TGT_W(TGT_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .line_en(line_en),
      .zero_mask(zero_mask), .clr_mask(clr_mask)
   );

   irqmap_arb #(.N_PCI(N_PCI), .N_OB(N_OB)) u_arb (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .irq_lvl(irq_lvl), .line_en(line_en),
      .kill_mask(zero_mask | clr_mask),
      .req_id(req_id), .req_vec(req_vec)
   );

   irqmap_route #(.N_PCI(N_PCI), .GRP(GRP), .SLOT_W(SLOT_W)) u_route (
      .slot(rt_slot), .pin(rt_pin), .fn_lsb(rt_fn_lsb), .line(rt_line)
   );
endmodule

// File: rtl/irqmap_ctrl_chk.sv
module irqmap_ctrl_chk #(
   parameter int N_PCI  = irqmap_pkg::DEF_N_PCI,
   parameter int N_OB   = irqmap_pkg::DEF_N_OB,
   parameter int GRP    = irqmap_pkg::DEF_GRP,
   parameter int ADDR_W = irqmap_pkg::DEF_ADDR_W
) (
   input logic                        clk,
   input logic                        por_n,
   input logic                        rst_n,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [$clog2(N_PCI+N_OB):0] req_id,
   input logic [N_PCI+N_OB-1:0]       req_vec
);
   localparam int ID_W     = $clog2(N_PCI + N_OB) + 1;
   localparam int GRP_SH   = $clog2(GRP);
   localparam int PIDX_W   = $clog2(N_PCI / GRP);
   localparam int OIDX_W   = $clog2(N_OB);
   localparam int PCLR_LSB = 3 + GRP_SH;
   localparam logic [ID_W-1:0] ID_NONE = '1;

   logic pclr_hit, oclr_hit;
   assign pclr_hit = bus_wr && bus_addr[2] && (bus_addr[11:8] == 4'h2) &&
                     (req_id < ID_W'(N_PCI)) &&
                     ((req_id >> GRP_SH) == ID_W'(bus_addr[PCLR_LSB +: PIDX_W]));
   assign oclr_hit = bus_wr && bus_addr[2] && (bus_addr[11:8] == 4'h3) &&
                     (req_id == ID_W'(N_PCI) + ID_W'(bus_addr[3 +: OIDX_W]));

   // R10
   vec_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0(req_vec));

   // R10
   vec_none_chk: assert property (@(posedge clk) disable iff (!por_n)
      (req_id != ID_NONE) |-> ($countones(req_vec) == 1));

   // R9
   reset_req_chk: assert property (@(posedge clk) disable iff (!por_n)
      !$past(rst_n) |-> (req_id == ID_NONE));

   // R4
   ob_grant_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      ((req_id != $past(req_id)) && (req_id >= ID_W'(N_PCI)) && (req_id != ID_NONE))
      |-> ($past(req_id) == ID_NONE));

   // R7
   pci_clr_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      pclr_hit |=> (req_id == ID_NONE));

   // R7
   ob_clr_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      oclr_hit |=> (req_id == ID_NONE));
endmodule

bind irqmap_ctrl irqmap_ctrl_chk #(
   .N_PCI(N_PCI), .N_OB(N_OB), .GRP(GRP), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .req_id(req_id), .req_vec(req_vec)
);

// File: tb/irqmap_ctrl_tb_top.sv
module irqmap_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] NONE = 7'h7F;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] irq_lvl = '0;
   logic [6:0]  req_id;
   logic [63:0] req_vec;
   logic [4:0]  rt_slot = '0;
   logic [1:0]  rt_pin = '0;
   logic        rt_fn_lsb = 1'b0;
   logic [4:0]  rt_line;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   irqmap_ctrl dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_lvl(irq_lvl), .req_id(req_id), .req_vec(req_vec),
      .rt_slot(rt_slot), .rt_pin(rt_pin), .rt_fn_lsb(rt_fn_lsb), .rt_line(rt_line)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_req(input string tag, input logic [6:0] exp);
      logic [63:0] ev;
      ev = (exp == NONE) ? 64'h0 : (64'h1 << exp);
      check({tag, " req_id"}, {57'h0, req_id}, {57'h0, exp});
      check({tag, " req_vec"}, req_vec, ev);
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_line(input int n, input logic v);
      @(negedge clk);
      irq_lvl[n] = v;
      @(posedge clk); #1;
   endtask

   task automatic t_power_on();
      logic [31:0] d;
      check_req("R9 por", NONE);
      rd(12'h01C, d); check("R9 por pci map3", {32'h0, d}, 64'h7CC);
      rd(12'h12C, d); check("R9 por ob map5", {32'h0, d}, 64'h7E5);
      rd(12'h018, d); check("R9 even word", {32'h0, d}, 64'h0);
   endtask

   task automatic t_pci_enable();
      set_line(5, 1'b1);  check_req("R3 disabled line", NONE);
      set_line(5, 1'b0);
      wr(12'h00C, 32'h8000_0000);
      check_req("R3 enable, line low", NONE);
      set_line(5, 1'b1);  check_req("R3 R1 line5 via map1", 7'd5);
   endtask

   task automatic t_pci_preempt();
      wr(12'h024, 32'h8000_0040);
      set_line(17, 1'b1); check_req("R3 preempt by line17", 7'd17);
   endtask

   task automatic t_pci_clear();
      wr(12'h2A4, 32'h0); check_req("R7 pci clear wrong index", 7'd17);
      wr(12'h284, 32'h0); check_req("R7 pci clear index4", NONE);
      tick();             check_req("R8 lowest regrant", 7'd5);
   endtask

   task automatic t_onboard();
      set_line(17, 1'b0);
      wr(12'h11C, 32'h8000_0000);
      wr(12'h144, 32'h8000_0000);
      set_line(40, 1'b1); check_req("R4 ob held off 40", 7'd5);
      set_line(35, 1'b1); check_req("R4 ob held off 35", 7'd5);
      wr(12'h00C, 32'h0000_0040); check_req("R6 nonzero write keeps", 7'd5);
      wr(12'h00C, 32'h0000_0000); check_req("R6 zero write retires", NONE);
      tick();             check_req("R8 R4 lowest onboard", 7'd35);
   endtask

   task automatic t_ob_clear();
      set_line(35, 1'b0); set_line(40, 1'b0); set_line(5, 1'b0);
      check_req("R7 request held after line drops", 7'd35);
      wr(12'h324, 32'h0); check_req("R7 ob clear wrong index", 7'd35);
      wr(12'h31C, 32'h0); check_req("R7 ob clear index3", NONE);
      tick(); tick();     check_req("R8 nothing pending", NONE);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(12'h014, 32'hFFFF_FFFF);
      rd(12'h014, d); check("R5 ro field kept", {32'h0, d}, 64'h8000_07C8);
      rd(12'h010, d); check("R9 even word zero", {32'h0, d}, 64'h0);
      rd(12'h11C, d); check("R5 ob map3 read", {32'h0, d}, 64'h8000_0023);
      rd(12'h31C, d); check("R9 clear region reads zero", {32'h0, d}, 64'h0);
   endtask

   task automatic t_route();
      rt_fn_lsb = 1'b1; rt_slot = 5'd3; rt_pin = 2'd2; #1;
      check("R2 route 3/2/1", {59'h0, rt_line}, 64'd30);
      rt_fn_lsb = 1'b1; rt_slot = 5'd5; rt_pin = 2'd3; #1;
      check("R2 route wraps", {59'h0, rt_line}, 64'd7);
      rt_fn_lsb = 1'b0; rt_slot = 5'd0; rt_pin = 2'd1; #1;
      check("R2 route 0/1/0", {59'h0, rt_line}, 64'd1);
   endtask

   task automatic t_warm_reset();
      logic [31:0] d;
      set_line(17, 1'b1); check_req("R8 idle grant", 7'd17);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1 check_req("R9 warm reset", NONE);
      rd(12'h024, d); check("R9 warm pci map4", {32'h0, d}, 64'h10);
      rd(12'h11C, d); check("R9 warm ob map3", {32'h0, d}, 64'h23);
      tick();         check_req("R1 disabled after warm", NONE);
      set_line(17, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
      #1;
      t_power_on();
      t_pci_enable();
      t_pci_preempt();
      t_pci_clear();
      t_onboard();
      t_ob_clear();
      t_regs();
      t_route();
      t_warm_reset();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule